// File: doc/BRIEF.md
# Periodic Battery Test Scheduler

This block decides when a backup battery is put under a test load and keeps a warning flag for a weak battery. Once the main supply reports good, a start delay runs, then a first test, then a test at every long interval. During a test the load-enable output is high for a fixed number of cycles. The block samples a comparator input that says whether the battery is above its trip level. A single low sample anywhere in that window marks the test as failed.

A failed test raises the warning. Passing periodic tests do not clear it, and neither does losing power. Only two things clear it: a test that passes right after power comes back, or a new battery being fitted, seen as the rising edge of a presence input. If power drops, the load is removed in the same cycle and the schedule stops. A test cut short this way gives no verdict. The warning leaves the block as the enable of an open-drain pull-down.

All pins are plain control and status levels. The block moves no data stream, so it has no valid/ready handshake and no back-pressure.

Top module: `batt_test_sched`

## Requirements
- R1: While `rst_n` is low and right after it is released, `load_en` is 0 and `warn_sink` is 0.
- R2: If posedge k is the first edge that samples `pwr_good` high, `load_en` goes high after posedge k+START_DLY_CYC and is low before it. Every new rise of `pwr_good` starts this delay again from zero.
- R3: Each test holds `load_en` high for exactly WINDOW_CYC consecutive cycles.
- R4: While power stays good, the next test begins INTERVAL_CYC cycles after the previous window ends. The cycle before each test start has `load_en` low.
- R5: `batt_ok` = 0 means below the trip point. If the posedge that ends a window, or any earlier posedge inside the window, samples `batt_ok` low, then `warn_sink` is 1 from that window-ending posedge on.
- R6: The warning is sticky. A passing periodic test does not clear it, and a loss of `pwr_good` does not clear it.
- R7: A passing test that is the first test after a `pwr_good` rise clears `warn_sink` at the posedge that ends its window.
- R8: When `pwr_good` is low, `load_en` is 0 in the same cycle, without waiting for a clock edge. A test cut short by a power drop leaves `warn_sink` unchanged, even if `batt_ok` was low during it.
- R9: A rising edge on `batt_present` (0 then 1 on consecutive posedges) clears `warn_sink` at the posedge that samples the 1.
- R10: `warn_sink` = 1 means the open-drain warning pin is pulled low. 0 means the pin is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pwr_good | input | 1 | Main supply within tolerance |
| batt_ok | input | 1 | Comparator: 1 when battery is above the trip point |
| batt_present | input | 1 | Battery fitted; a rising edge marks a replacement |
| load_en | output | 1 | Connect the test load to the battery |
| warn_sink | output | 1 | Pull-down enable of the open-drain warning pin |

## Verification
The bench builds the block with START_DLY_CYC = 5, WINDOW_CYC = 4 and INTERVAL_CYC = 20. With these values a whole day's schedule shrinks to a few dozen cycles. Several power cycles, periodic passes and failures, a one-cycle comparator dip, a test interrupted by a power drop and a battery swap therefore all fit into one short run. The exact cycle of each load edge and warning change is checked against values computed from these three numbers.

// File: rtl/bts_pkg.sv
package bts_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_DELAY = 2'd1,
    ST_TEST  = 2'd2,
    ST_WAIT  = 2'd3
  } bts_state_e;

  function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                       input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/bts_counter.sv
module bts_counter #(
  parameter int unsigned CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic [CW-1:0] limit,
  output logic          hit
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt <= '0;
    else if (clr) cnt <= '0;
    else          cnt <= cnt + 1'b1;
  end

  // hit marks the last cycle of a phase that lasts "limit" cycles
  assign hit = (cnt == limit - 1'b1);

endmodule

// File: rtl/bts_seq.sv
module bts_seq
  import bts_pkg::*;
#(
  parameter int unsigned CW            = 8,
  parameter int unsigned START_DLY_CYC = 5,
  parameter int unsigned WINDOW_CYC    = 4,
  parameter int unsigned INTERVAL_CYC  = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_good,
  output logic in_test,
  output logic test_done,
  output logic pwrup_test
);
  localparam logic [CW-1:0] LIM_DLY = CW'(START_DLY_CYC);
  localparam logic [CW-1:0] LIM_WIN = CW'(WINDOW_CYC);
  localparam logic [CW-1:0] LIM_INT = CW'(INTERVAL_CYC);

  bts_state_e    st, st_nx;
  logic [CW-1:0] limit;
  logic          hit;
  logic          cnt_clr;

  always_comb begin
    unique case (st)
      ST_TEST: limit = LIM_WIN;
      ST_WAIT: limit = LIM_INT;
      default: limit = LIM_DLY;
    endcase
  end

  always_comb begin
    st_nx = st;
    if (!pwr_good) begin
      st_nx = ST_IDLE;
    end else begin
      unique case (st)
        ST_IDLE:  st_nx = ST_DELAY;
        ST_DELAY: if (hit) st_nx = ST_TEST;
        ST_TEST:  if (hit) st_nx = ST_WAIT;
        ST_WAIT:  if (hit) st_nx = ST_TEST;
        default:  st_nx = ST_IDLE;
      endcase
    end
  end

  assign cnt_clr = (st_nx != st) || (st == ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= ST_IDLE;
    else        st <= st_nx;
  end

  // Marks whether the running test is the first one after power came up
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                  pwrup_test <= 1'b0;
    else if (st == ST_DELAY && st_nx == ST_TEST) pwrup_test <= 1'b1;
    else if (st == ST_WAIT && st_nx == ST_TEST)  pwrup_test <= 1'b0;
  end

  bts_counter #(.CW(CW)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (cnt_clr),
    .limit (limit),
    .hit   (hit)
  );

  assign in_test   = (st == ST_TEST);
  assign test_done = (st == ST_TEST) && hit && pwr_good;

  // R8
  nopwr_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_good |=> (st == ST_IDLE));

  // R4
  wait_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_WAIT) |=> (st != ST_DELAY));

  // R2
  delay_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_DELAY) |=> (st != ST_WAIT));

  // R3
  done_in_test_chk: assert property (@(posedge clk) disable iff (!rst_n)
    test_done |=> (st == ST_WAIT));

endmodule

// File: rtl/bts_verdict.sv
module bts_verdict (
  input  logic clk,
  input  logic rst_n,
  input  logic in_test,
  input  logic test_done,
  input  logic pwrup_test,
  input  logic batt_ok,
  input  logic batt_present,
  output logic warn
);
  logic fail_acc;
  logic final_fail;
  logic present_q;
  logic present_rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     fail_acc <= 1'b0;
    else if (!in_test || test_done) fail_acc <= 1'b0;
    else if (!batt_ok)              fail_acc <= 1'b1;
  end

  assign final_fail = fail_acc | ~batt_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) present_q <= 1'b0;
    else        present_q <= batt_present;
  end

  assign present_rise = batt_present & ~present_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        warn <= 1'b0;
    else if (test_done && final_fail)  warn <= 1'b1;
    else if (present_rise)             warn <= 1'b0;
    else if (test_done && pwrup_test)  warn <= 1'b0;
  end

  // R6
  sticky_warn_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (warn && !present_rise && !(test_done && pwrup_test)) |=> warn);

  // R8
  verdict_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!test_done && !present_rise) |=> $stable(warn));

  // R5
  fail_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (test_done && !batt_ok) |=> warn);

endmodule

// File: rtl/batt_test_sched.sv
module batt_test_sched
  import bts_pkg::*;
#(
  parameter int unsigned START_DLY_CYC = 100,
  parameter int unsigned WINDOW_CYC    = 1000,
  parameter int unsigned INTERVAL_CYC  = 86_400_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_good,
  input  logic batt_ok,
  input  logic batt_present,
  output logic load_en,
  output logic warn_sink
);
  localparam int unsigned MAXC = max3(START_DLY_CYC, WINDOW_CYC, INTERVAL_CYC);
  localparam int unsigned CW   = $clog2(MAXC + 1);

  logic in_test;
  logic test_done;
  logic pwrup_test;
  logic warn;

  bts_seq #(
    .CW            (CW),
    .START_DLY_CYC (START_DLY_CYC),
    .WINDOW_CYC    (WINDOW_CYC),
    .INTERVAL_CYC  (INTERVAL_CYC)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .pwr_good   (pwr_good),
    .in_test    (in_test),
    .test_done  (test_done),
    .pwrup_test (pwrup_test)
  );

  bts_verdict u_verdict (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_test      (in_test),
    .test_done    (test_done),
    .pwrup_test   (pwrup_test),
    .batt_ok      (batt_ok),
    .batt_present (batt_present),
    .warn         (warn)
  );

  // Load is cut combinationally the moment power is lost
  assign load_en   = in_test & pwr_good;
  assign warn_sink = warn;

  // Run-length counter for the window check below
  logic [CW-1:0] load_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       load_run <= '0;
    else if (load_en) load_run <= load_run + 1'b1;
    else              load_run <= '0;
  end

  // R3
  window_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_run <= CW'(WINDOW_CYC));

  // R8
  load_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pwr_good) |-> !load_en);

endmodule

// File: tb/sim_batt_test_sched.sv
`timescale 1ns/100ps
module sim_batt_test_sched;
  localparam int unsigned D = 5;
  localparam int unsigned W = 4;
  localparam int unsigned I = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pwr_good = 1'b0;
  logic batt_ok = 1'b1;
  logic batt_present = 1'b1;
  logic load_en;
  logic warn_sink;

  always #2.5 clk = ~clk;

  batt_test_sched #(
    .START_DLY_CYC (D),
    .WINDOW_CYC    (W),
    .INTERVAL_CYC  (I)
  ) u0 (
    .clk          (clk),
    .rst_n        (rst_n),
    .pwr_good     (pwr_good),
    .batt_ok      (batt_ok),
    .batt_present (batt_present),
    .load_en      (load_en),
    .warn_sink    (warn_sink)
  );

  typedef struct {
    int    cyc;
    bit    is_warn;
    bit    val;
    string req;
  } exp_t;

  exp_t q[$];
  int   cyc = 0;
  int   n_chk = 0;
  int   n_fail = 0;
  bit   finished = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic expect_at(input int c, input bit w, input bit v, input string r);
    exp_t e;
    e.cyc = c; e.is_warn = w; e.val = v; e.req = r;
    q.push_back(e);
  endtask

  task automatic wait_cyc(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  task automatic power_up(output int p);
    @(negedge clk);
    pwr_good = 1'b1;
    p = cyc + 1;
  endtask

  // Monitor: compares outputs against queued expectations
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (q.size() > 0 && q[0].cyc <= cyc) begin
        exp_t e;
        logic act;
        e = q.pop_front();
        act = e.is_warn ? warn_sink : load_en;
        n_chk++;
        if (e.cyc < cyc || act !== e.val) begin
          n_fail++;
          $display("FAIL %s cyc=%0d %s actual=%b expected=%b", e.req, e.cyc,
                   e.is_warn ? "warn_sink" : "load_en", act, e.val);
        end
      end
    end
  end

  initial begin
    int p1, p2, p3, t2, t3, t4, t5, c0, c;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    expect_at(cyc, 1'b0, 1'b0, "R1");
    expect_at(cyc, 1'b1, 1'b0, "R1");
    wait_cyc(cyc + 2);

    // First power-up: passing test (R2, R3)
    power_up(p1);
    expect_at(p1 + D - 1, 1'b0, 1'b0, "R2");
    expect_at(p1 + D,     1'b0, 1'b1, "R2");
    expect_at(p1 + D + W - 1, 1'b0, 1'b1, "R3");
    expect_at(p1 + D + W, 1'b0, 1'b0, "R3");
    expect_at(p1 + D + W, 1'b1, 1'b0, "R7");

    // Periodic test cut by a power drop while the battery reads low (R4, R8)
    t2 = p1 + D + W + I;
    expect_at(t2 - 1, 1'b0, 1'b0, "R4");
    expect_at(t2,     1'b0, 1'b1, "R4");
    wait_cyc(t2);
    batt_ok = 1'b0;
    wait_cyc(t2 + 1);
    pwr_good = 1'b0;
    expect_at(t2 + 1, 1'b0, 1'b0, "R8");
    wait_cyc(t2 + 3);
    batt_ok = 1'b1;
    expect_at(t2 + W + 2, 1'b1, 1'b0, "R8");
    wait_cyc(t2 + 8);

    // Second power-up, then a periodic test with a one-cycle dip (R2, R5)
    power_up(p2);
    expect_at(p2 + D - 1, 1'b0, 1'b0, "R2");
    expect_at(p2 + D,     1'b0, 1'b1, "R2");
    t3 = p2 + D + W + I;
    expect_at(t3,         1'b0, 1'b1, "R4");
    expect_at(t3 + W - 1, 1'b1, 1'b0, "R5");
    expect_at(t3 + W,     1'b1, 1'b1, "R5");
    expect_at(t3 + W,     1'b0, 1'b0, "R3");
    wait_cyc(t3 + 1);
    batt_ok = 1'b0;
    wait_cyc(t3 + 2);
    batt_ok = 1'b1;

    // Passing periodic test keeps the warning (R6)
    t4 = t3 + W + I;
    expect_at(t4,         1'b0, 1'b1, "R4");
    expect_at(t4 + W,     1'b1, 1'b1, "R6");
    expect_at(t4 + W + 1, 1'b1, 1'b1, "R6");
    wait_cyc(t4 + W + 3);

    // Power loss keeps it; power-up test that passes clears it (R6, R7)
    pwr_good = 1'b0;
    c0 = cyc;
    expect_at(c0 + 2, 1'b1, 1'b1, "R6");
    expect_at(c0 + 2, 1'b0, 1'b0, "R8");
    wait_cyc(c0 + 3);
    power_up(p3);
    expect_at(p3 + D,         1'b0, 1'b1, "R2");
    expect_at(p3 + D + W - 1, 1'b1, 1'b1, "R7");
    expect_at(p3 + D + W,     1'b1, 1'b0, "R7");

    // Periodic test fails outright, then a battery swap clears (R5, R9, R10)
    t5 = p3 + D + W + I;
    wait_cyc(t5 - 1);
    batt_ok = 1'b0;
    expect_at(t5 + W, 1'b1, 1'b1, "R10");
    wait_cyc(t5 + W + 1);
    batt_ok = 1'b1;
    batt_present = 1'b0;
    c = cyc;
    expect_at(c + 2, 1'b1, 1'b1, "R9");
    expect_at(c + 3, 1'b1, 1'b0, "R9");
    wait_cyc(c + 2);
    batt_present = 1'b1;
    wait_cyc(c + 6);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #20000;
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule